// File: doc/BRIEF.md
# Clock Ratio Measurement Unit

This block measures the frequency relationship between two slow clocks, a byte clock and a parallel data clock, and the fast system clock that samples them. The results feed a numerically controlled oscillator loop. Both slow clocks pass through synchronizers into the system clock domain. Only their rising edges are used.

A measurement has two phases. Phase one counts data clock edges in each byte clock period. It runs over a probe window whose length is a register value times 2^WIN_SHIFT byte periods. The count from the last period of the window becomes the result n. Phase two then counts system clock cycles across n − 1 data clock periods.

Software writes a start bit and polls a done flag. A second function counts sync pulses and emits an update strobe at a programmable interval. The measurement and the strobe are active only while the PLL mode input selects the measuring mode.

Top module: `clk_ratio_meter`

## Requirements
- R1: After reset these registers read as follows: probe length (address 1) is 0, update interval (address 2) is 1, per-byte count (address 3) is 0, system count (address 4) is 0, and control/status (address 0) is 0.
- R2: In mode 2, writing bit 0 of address 0 while idle with a non-zero probe length makes the unit busy. In the next cycle it clears done, overflow and both results. Status bits at address 0 are: bit 0 busy, bit 1 done, bit 2 overflow.
- R3: The per-byte result is the number of data clock rising edges in the final byte period of a window of probe × 2^WIN_SHIFT byte periods. An edge detected in the same cycle as a byte clock edge is counted in the new period.
- R4: The system count equals the number of system clock cycles from the detection of one data clock edge to the detection of the (n − 1)-th edge after it.
- R5: Done is set together with the final results and is never set while busy.
- R6: A start with probe length 0 completes at once: done is set and both results stay 0.
- R7: If the system count would exceed its width, it saturates at all ones and the overflow bit is set.
- R8: When mode_i is not 2, a start has no effect and no update strobe is produced.
- R9: update_o pulses for one cycle, in the cycle after the sync pulse that brings the sync count up to the interval value. The count then restarts from zero.
- R10: With the reset interval of 1, every sync pulse produces a strobe.
- R11: When n is 1 or less, phase two is skipped: done is set and the system count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Byte clock, asynchronous |
| pclk_i | input | 1 | Parallel data clock, asynchronous |
| sync_i | input | 1 | One-cycle sync pulse, system domain |
| mode_i | input | 2 | PLL mode select; value 2 enables the unit |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_we_i | input | 1 | Register write enable |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| update_o | output | 1 | NCO step update strobe |

## Verification
The hardest state to reach from the ports is saturation of the system count. With a 24-bit counter it would need millions of cycles. The bench therefore builds the unit with a narrow count and a short window. It then drives a data clock slow enough that n − 1 periods exceed the counter range. Aligned clock patterns put data and byte clock edges in the same cycle, which exercises the rule that such an edge belongs to the new period. Equal clock periods drive n down to 1.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM1, ST_MEAS1, ST_ARM2, ST_MEAS2
  } meas_state_e;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_PROBE  = 3'd1;
  localparam logic [2:0] ADDR_UPD    = 3'd2;
  localparam logic [2:0] ADDR_NPER   = 3'd3;
  localparam logic [2:0] ADDR_SYSCNT = 3'd4;

  localparam logic [1:0] MODE_MEAS = 2'd2;
endpackage

// File: rtl/crm_edge_sync.sv
module crm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], async_i};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/crm_meter.sv
module crm_meter
  import clk_ratio_pkg::*;
#(
  parameter int PROBE_W   = 16,
  parameter int WIN_SHIFT = 8,
  parameter int NPER_W    = 8,
  parameter int SYS_W     = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               start_i,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               brise_i,
  input  logic               prise_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               ovf_o,
  output logic [NPER_W-1:0]  nper_o,
  output logic [SYS_W-1:0]   sys_o
);
  localparam int WIN_W = PROBE_W + WIN_SHIFT;

  meas_state_e       state_q;
  logic [WIN_W-1:0]  win_len_q, win_cnt_q;
  logic [NPER_W-1:0] per_cnt_q, per_inc, need_q, edge_cnt_q;
  logic [SYS_W-1:0]  sys_cnt_q, sys_next;
  logic              sat_q, sys_at_max;

  assign per_inc    = (per_cnt_q == '1) ? per_cnt_q : per_cnt_q + 1'b1;
  assign sys_at_max = (sys_cnt_q == '1);
  assign sys_next   = sys_at_max ? sys_cnt_q : sys_cnt_q + 1'b1;
  assign busy_o     = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      win_len_q  <= '0;
      win_cnt_q  <= '0;
      per_cnt_q  <= '0;
      need_q     <= '0;
      edge_cnt_q <= '0;
      sys_cnt_q  <= '0;
      sat_q      <= 1'b0;
      done_o     <= 1'b0;
      ovf_o      <= 1'b0;
      nper_o     <= '0;
      sys_o      <= '0;
    end else if (!enable_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          done_o    <= (probe_i == '0);
          ovf_o     <= 1'b0;
          nper_o    <= '0;
          sys_o     <= '0;
          win_len_q <= WIN_W'(probe_i) << WIN_SHIFT;
          if (probe_i != '0) state_q <= ST_ARM1;
        end
        ST_ARM1: if (brise_i) begin
          state_q   <= ST_MEAS1;
          win_cnt_q <= '0;
          per_cnt_q <= prise_i ? NPER_W'(1) : '0;
        end
        ST_MEAS1: begin
          if (brise_i) begin
            if (win_cnt_q + WIN_W'(1) == win_len_q) begin
              nper_o <= per_cnt_q;
              need_q <= per_cnt_q - 1'b1;
              if (per_cnt_q <= NPER_W'(1)) begin
                done_o  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_ARM2;
              end
            end
            win_cnt_q <= win_cnt_q + 1'b1;
            per_cnt_q <= prise_i ? NPER_W'(1) : '0;
          end else if (prise_i) begin
            per_cnt_q <= per_inc;
          end
        end
        ST_ARM2: if (prise_i) begin
          state_q    <= ST_MEAS2;
          sys_cnt_q  <= '0;
          edge_cnt_q <= '0;
          sat_q      <= 1'b0;
        end
        ST_MEAS2: begin
          sys_cnt_q <= sys_next;
          sat_q     <= sat_q | sys_at_max;
          if (prise_i) begin
            if (edge_cnt_q + 1'b1 == need_q) begin
              sys_o   <= sys_next;
              ovf_o   <= sat_q | sys_at_max;
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end
            edge_cnt_q <= edge_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o)); // R5
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && enable_i && !busy_o && probe_i != '0) |=>
      (busy_o && !done_o && !ovf_o && sys_o == '0 && nper_o == '0)); // R2
  AST_ZERO_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && enable_i && !busy_o && probe_i == '0) |=>
      (done_o && !busy_o && sys_o == '0 && nper_o == '0)); // R6
  AST_SATURATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (sys_o == '1)); // R7
  AST_MODE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !busy_o); // R8
endmodule

// File: rtl/crm_upd_tick.sv
module crm_upd_tick #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         clear_i,
  input  logic         sync_i,
  input  logic [W-1:0] interval_i,
  output logic         update_o
);
  logic [W-1:0] cnt_q;
  logic         hit;

  assign hit = enable_i && sync_i && ({1'b0, cnt_q} + 1'b1 >= {1'b0, interval_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      update_o <= 1'b0;
    end else begin
      update_o <= hit;
      if (!enable_i || clear_i) cnt_q <= '0;
      else if (sync_i)          cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  AST_UPD_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> ($past(sync_i) && $past(enable_i))); // R9
  AST_UPD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !update_o); // R8
endmodule

// File: rtl/clk_ratio_meter.sv
module clk_ratio_meter
  import clk_ratio_pkg::*;
#(
  parameter int PROBE_W     = 16,
  parameter int WIN_SHIFT   = 8,
  parameter int NPER_W      = 8,
  parameter int SYS_W       = 24,
  parameter int UPD_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bclk_i,
  input  logic        pclk_i,
  input  logic        sync_i,
  input  logic [1:0]  mode_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  input  logic        reg_we_i,
  output logic [31:0] reg_rdata_o,
  output logic        update_o
);
  localparam int NCLK = 2;

  logic [PROBE_W-1:0] probe_q;
  logic [UPD_W-1:0]   upd_q;
  logic [NCLK-1:0]    raw_clk, rise;
  logic               enable, start, upd_clear;
  logic               busy, done, ovf;
  logic [NPER_W-1:0]  nper;
  logic [SYS_W-1:0]   sys_cnt;

  assign enable    = (mode_i == MODE_MEAS);
  assign start     = reg_we_i && (reg_addr_i == ADDR_CTRL) && reg_wdata_i[0];
  assign upd_clear = reg_we_i && (reg_addr_i == ADDR_UPD);
  assign raw_clk   = {bclk_i, pclk_i};

  for (genvar g = 0; g < NCLK; g++) begin : g_sync
    crm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw_clk[g]),
      .rise_o (rise[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      probe_q <= '0;
      upd_q   <= UPD_W'(1);
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_PROBE) probe_q <= PROBE_W'(reg_wdata_i);
      if (reg_addr_i == ADDR_UPD)   upd_q   <= UPD_W'(reg_wdata_i);
    end
  end

  crm_meter #(
    .PROBE_W  (PROBE_W),
    .WIN_SHIFT(WIN_SHIFT),
    .NPER_W   (NPER_W),
    .SYS_W    (SYS_W)
  ) u_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable),
    .start_i (start),
    .probe_i (probe_q),
    .brise_i (rise[1]),
    .prise_i (rise[0]),
    .busy_o  (busy),
    .done_o  (done),
    .ovf_o   (ovf),
    .nper_o  (nper),
    .sys_o   (sys_cnt)
  );

  crm_upd_tick #(.W(UPD_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable),
    .clear_i   (upd_clear),
    .sync_i    (sync_i),
    .interval_i(upd_q),
    .update_o  (update_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL:   reg_rdata_o = {29'd0, ovf, done, busy};
      ADDR_PROBE:  reg_rdata_o = 32'(probe_q);
      ADDR_UPD:    reg_rdata_o = 32'(upd_q);
      ADDR_NPER:   reg_rdata_o = 32'(nper);
      ADDR_SYSCNT: reg_rdata_o = 32'(sys_cnt);
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/clk_ratio_meter_bench.sv
module clk_ratio_meter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_SHIFT  = 4;
  localparam int SYS_W      = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, pclk = 1'b0, sync = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        update;

  int total = 0, bad = 0, tick = 0, pper = 4, bper = 32;
  bit finished = 0;

  clk_ratio_meter #(.WIN_SHIFT(WIN_SHIFT), .SYS_W(SYS_W)) u_clk_ratio_meter (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .pclk_i(pclk), .sync_i(sync),
    .mode_i(mode), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we),
    .reg_rdata_o(rdata), .update_o(update)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick <= tick + 1;
    pclk <= (tick % pper) < (pper / 2);
    bclk <= (tick % bper) < (bper / 2);
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    addr = a; #1; d = int'(rdata);
  endtask

  task automatic wait_done(input string req);
    int st;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk); rd(3'd0, st);
      if (st[1]) return;
    end
    check({req, " done timeout"}, 0, 1);
  endtask

  task automatic pulse_sync(output bit seen);
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0; seen = update;
    @(negedge clk); if (update) check("R9 strobe width", 1, 0);
  endtask

  task automatic t_reset();
    int d;
    rd(3'd1, d); check("R1 probe reset", d, 0);
    rd(3'd2, d); check("R1 interval reset", d, 1);
    rd(3'd3, d); check("R1 nper reset", d, 0);
    rd(3'd4, d); check("R1 syscnt reset", d, 0);
    rd(3'd0, d); check("R1 ctrl reset", d, 0);
  endtask

  task automatic t_update_default();
    bit s;
    pulse_sync(s); check("R10 strobe per sync", int'(s), 1);
    pulse_sync(s); check("R10 strobe per sync 2nd", int'(s), 1);
  endtask

  task automatic t_update_interval();
    bit s;
    wr(3'd2, 16'd3);
    for (int i = 0; i < 6; i++) begin
      pulse_sync(s);
      check($sformatf("R9 interval 3 sync %0d", i), int'(s), (i % 3 == 2) ? 1 : 0);
    end
  endtask

  task automatic t_mode_gate();
    int d; bit s;
    mode = 2'd0;
    wr(3'd1, 16'd1);
    wr(3'd0, 16'd1);
    repeat (200) @(negedge clk);
    rd(3'd0, d); check("R8 start ignored", d, 0);
    wr(3'd2, 16'd1);
    pulse_sync(s); check("R8 no strobe", int'(s), 0);
    mode = 2'd2;
  endtask

  task automatic t_measure(input string tag, input int p, input int b, input int probe,
                           input int exp_n, input int exp_sys, input int exp_st);
    int d;
    pper = p; bper = b;
    repeat (4 * b) @(negedge clk);
    wr(3'd1, 16'(probe));
    wr(3'd0, 16'd1);
    wait_done(tag);
    rd(3'd3, d); check({tag, " nper"}, d, exp_n);
    rd(3'd4, d); check({tag, " syscnt"}, d, exp_sys);
    rd(3'd0, d); check({tag, " status"}, d, exp_st);
  endtask

  task automatic t_restart_clears();
    int d;
    @(negedge clk); addr = 3'd0; wdata = 16'd1; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(3'd0, d); check("R2 busy no done", d, 1);
    rd(3'd3, d); check("R2 nper cleared", d, 0);
    rd(3'd4, d); check("R2 syscnt cleared", d, 0);
    wait_done("R2");
  endtask

  task automatic t_zero_probe();
    int d;
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd1);
    rd(3'd0, d); check("R6 done at once", d, 2);
    rd(3'd3, d); check("R6 nper zero", d, 0);
    rd(3'd4, d); check("R6 syscnt zero", d, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_update_default();
    t_update_interval();
    t_mode_gate();
    t_measure("R3 R4 R5 p4 b32", 4, 32, 1, 8, 28, 2);
    t_restart_clears();
    t_measure("R3 R4 p6 b48 probe2", 6, 48, 2, 8, 42, 2);
    t_measure("R3 R4 p4 b24 probe3", 4, 24, 3, 6, 20, 2);
    t_measure("R11 single", 40, 40, 1, 1, 0, 2);
    t_measure("R7 saturate", 160, 1280, 1, 8, 1023, 6);
    t_zero_probe();
    summary();
  end
endmodule